// File: doc/BRIEF.md
# SPI Target with Buffer Ownership Semaphore

This block is the serial side of an SPI target. An external master drives chip select, clock and data-in; the block shifts bytes out of a local transmit byte buffer and into a local receive byte buffer, most significant bit first. Both buffers are plain byte arrays. The host side writes the transmit buffer and reads the receive buffer through a small word port.

Which side may touch the buffers is decided by a one-bit hardware semaphore. The host hands the buffers to the serial engine with a release strobe, and takes them back with an acquire strobe. A transaction only uses the buffers if the engine owns them when chip select falls. Such a transaction is called granted. When a granted transaction ends, an end event is raised. If auto re-acquire is on, ownership then returns to the host by itself.

A transaction that starts while the host holds the semaphore sends a fill character and leaves the buffers alone. Inside a granted transaction, bytes past the transmit limit are also replaced by a fill character. Two sticky events, each with an interrupt enable, drive one interrupt line.

Top module: `spis_target`

## Requirements
- R1: The mode is set by `cfg_cpol` (clock idle level) and `cfg_cpha`. With `cfg_cpha`=0, MOSI is sampled on the leading clock edge (the edge away from idle) and MISO changes on the trailing edge, with the first bit valid once chip select is low. With `cfg_cpha`=1, MISO changes on the leading edge and MOSI is sampled on the trailing edge. All four combinations work.
- R2: Every byte is shifted most significant bit first, in both directions.
- R3: In a granted transaction, MISO sends transmit buffer entries 0, 1, 2, ... up to `tx_max` bytes. `tx_amount` is cleared at the start and counts the buffer bytes whose eight bits have all been clocked.
- R4: In a granted transaction, received bytes go to receive buffer entries 0, 1, ... up to `rx_max`. Later bytes are not stored and not counted. `rx_amount` is cleared at the start and counts the stored bytes.
- R5: Once `tx_max` buffer bytes have been used in a granted transaction, each further byte sent is `cfg_orc`.
- R6: A transaction that starts while the host owns the semaphore sends `cfg_def` for every byte. It writes no receive entry, leaves both amounts unchanged, and raises no end event.
- R7: A `task_release` pulse gives the semaphore to the engine: `sem_host` reads 0 from the next cycle.
- R8: A `task_acquire` pulse outside a granted transaction makes `sem_host` 1 and sets `evt_acquired` on the next cycle. During a granted transaction, the grant is held back until that transaction ends. While a granted transaction runs, `sem_host` is always 0.
- R9: `evt_end` is set when chip select rises at the end of a granted transaction.
- R10: With `cfg_auto_acq`=1, the end of a granted transaction also grants the semaphore to the host and sets `evt_acquired`. With `cfg_auto_acq`=0, the engine keeps the semaphore.
- R11: Events stay set until a `evt_clr` strobe clears them. Bit 0 is end and bit 1 is acquired, in `evt_clr`, `inten_set`, `inten_clr` and `inten`. `irq` is the OR of the set events that are enabled. Writing `inten_clr`=2'b11 disables every event interrupt.
- R12: `miso_oe` is 0 whenever `csn_n` is high.
- R13: After reset: `sem_host`=1, events 0, `inten`=0, both amounts 0, and every receive entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from master |
| csn_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master |
| miso_oe | output | 1 | Output enable for MISO |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_orc | input | 8 | Fill byte after transmit limit |
| cfg_def | input | 8 | Fill byte for transactions that are not granted |
| cfg_auto_acq | input | 1 | Re-acquire on end |
| tx_max | input | CNT_W | Transmit byte limit |
| rx_max | input | CNT_W | Receive byte limit |
| task_acquire | input | 1 | Acquire strobe |
| task_release | input | 1 | Release strobe |
| evt_clr | input | 2 | Event clear mask strobe |
| inten_set | input | 2 | Interrupt enable set mask |
| inten_clr | input | 2 | Interrupt enable clear mask |
| host_addr | input | AW | Host buffer index |
| host_tx_we | input | 1 | Transmit buffer write strobe |
| host_tx_wdata | input | 8 | Transmit buffer write byte |
| host_rx_rdata | output | 8 | Receive buffer byte at host_addr |
| sem_host | output | 1 | 1 while the host owns the semaphore |
| evt_end | output | 1 | End event |
| evt_acquired | output | 1 | Acquired event |
| inten | output | 2 | Interrupt enables |
| irq | output | 1 | Interrupt request |
| tx_amount | output | CNT_W | Buffer bytes sent |
| rx_amount | output | CNT_W | Bytes stored |

## Verification
The assertions rely on the host not changing `tx_max` or `rx_max` while a transaction is in progress, and on both limits being at most the buffer depth. The stimulus only writes the limits while chip select is high, and every value it uses fits the buffer.

The assertions also rely on the SCK half period being several system clocks long, so that no edge is lost in the synchronisers. The stimulus holds each SCK level and the chip-select setup and hold for eight system cycles.

// File: rtl/spis_pkg.sv
// Shared types for the SPI target: semaphore owner encoding, mode bundle
// and event bit positions. Assumes byte-wide data throughout.
package spis_pkg;
    typedef enum logic {
        OWN_ENGINE = 1'b0,
        OWN_HOST   = 1'b1
    } owner_t;

    typedef struct packed {
        logic cpol;
        logic cpha;
    } spi_mode_t;

    localparam int EVT_END = 0;
    localparam int EVT_ACQ = 1;
    localparam int N_EVT   = 2;
endpackage

// File: rtl/spis_sync.sv
// Two-flop synchroniser bank for asynchronous pin inputs.
// Assumes each input is held for several system clocks; RST_VAL gives
// the idle level of each bit so no false edge appears after reset.
module spis_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Two flops in series per pin bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta[i] <= RST_VAL[i];
                q[i]    <= RST_VAL[i];
            end else begin
                meta[i] <= d[i];
                q[i]    <= meta[i];
            end
        end
    end
endmodule

// File: rtl/spis_sema.sv
// Buffer ownership semaphore, sticky events and interrupt enables.
// Assumes busy marks a granted transaction and start_grant pulses the
// cycle one is being granted; a start in that cycle defers a host grant.
module spis_sema
    import spis_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             task_acq,
    input  logic             task_rel,
    input  logic             auto_acq,
    input  logic             busy,
    input  logic             start_grant,
    input  logic             end_pulse,
    input  logic [N_EVT-1:0] evt_clr,
    input  logic [N_EVT-1:0] inten_set,
    input  logic [N_EVT-1:0] inten_clr,
    output logic             sem_host,
    output logic             engine_owns,
    output logic [N_EVT-1:0] evt,
    output logic [N_EVT-1:0] inten,
    output logic             irq
);
    owner_t owner;
    logic   pend;
    logic   acq_req, can_grant, grant_now;
    logic [N_EVT-1:0] evt_set;

    // Decide whether a host grant happens this cycle.
    always_comb begin
        acq_req   = task_acq | (end_pulse & auto_acq);
        can_grant = (!busy && !start_grant) || end_pulse;
        grant_now = (acq_req || pend) && can_grant && !task_rel;
        evt_set   = '0;
        evt_set[EVT_END] = end_pulse;
        evt_set[EVT_ACQ] = grant_now;
    end

    // Ownership and pending-acquire state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner <= OWN_HOST;
            pend  <= 1'b0;
        end else if (task_rel) begin
            owner <= OWN_ENGINE;
            pend  <= 1'b0;
        end else if (grant_now) begin
            owner <= OWN_HOST;
            pend  <= 1'b0;
        end else if (acq_req) begin
            pend  <= 1'b1;
        end
    end

    // Sticky events (set wins) and interrupt enables (clear wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt   <= '0;
            inten <= '0;
        end else begin
            evt   <= (evt & ~evt_clr) | evt_set;
            inten <= (inten | inten_set) & ~inten_clr;
        end
    end

    assign sem_host    = (owner == OWN_HOST);
    assign engine_owns = (owner == OWN_ENGINE);
    assign irq         = |(evt & inten);
endmodule

// File: rtl/spis_engine.sv
// Serial shift engine with local transmit and receive byte buffers.
// Assumes synchronised pin levels; detects SCK and CSN edges itself.
// A transaction is granted if the engine owns the semaphore at CSN fall.
module spis_engine
    import spis_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  spi_mode_t        mode,
    input  logic             sck_s,
    input  logic             csn_s,
    input  logic             mosi_s,
    input  logic             engine_owns,
    input  logic [CNT_W-1:0] tx_max,
    input  logic [CNT_W-1:0] rx_max,
    input  logic [7:0]       orc,
    input  logic [7:0]       def,
    input  logic [AW-1:0]    host_addr,
    input  logic             host_tx_we,
    input  logic [7:0]       host_tx_wdata,
    output logic [7:0]       host_rx_rdata,
    output logic             miso_bit,
    output logic             granted,
    output logic             start_grant,
    output logic             end_pulse,
    output logic [CNT_W-1:0] tx_amount,
    output logic [CNT_W-1:0] rx_amount
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic [7:0] tx_mem [DEPTH];
    logic [7:0] rx_mem [DEPTH];

    logic             sck_q, csn_q;
    logic             sck_rise, sck_fall, csn_fall, csn_rise;
    logic             lead_e, trail_e, sample_e, shift_e;
    logic [7:0]       tx_sh, rx_sh;
    logic [2:0]       bit_cnt;
    logic             need_load, cur_buf;
    logic [CNT_W-1:0] tx_idx, tx_lim, rx_lim;
    logic [CNT_W-1:0] pick_idx;
    logic             pick_g, pick_buf;
    logic [7:0]       pick_byte, rx_next;

    // Previous pin levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            csn_q <= 1'b1;
        end else begin
            sck_q <= sck_s;
            csn_q <= csn_s;
        end
    end

    // Edge classification by mode and byte source selection.
    always_comb begin
        sck_rise  = sck_s & ~sck_q;
        sck_fall  = ~sck_s & sck_q;
        csn_fall  = csn_q & ~csn_s;
        csn_rise  = ~csn_q & csn_s;
        lead_e    = mode.cpol ? sck_fall : sck_rise;
        trail_e   = mode.cpol ? sck_rise : sck_fall;
        sample_e  = mode.cpha ? trail_e : lead_e;
        shift_e   = mode.cpha ? lead_e : trail_e;
        tx_lim    = (tx_max > DEPTH_C) ? DEPTH_C : tx_max;
        rx_lim    = (rx_max > DEPTH_C) ? DEPTH_C : rx_max;
        pick_idx  = csn_fall ? '0 : tx_idx;
        pick_g    = csn_fall ? engine_owns : granted;
        pick_buf  = pick_g && (pick_idx < tx_lim);
        pick_byte = !pick_g ? def : (pick_buf ? tx_mem[pick_idx[AW-1:0]] : orc);
        rx_next   = {rx_sh[6:0], mosi_s};
    end

    // Host writes into the transmit buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tx_mem[i] <= '0;
        end else if (host_tx_we) begin
            tx_mem[host_addr] <= host_tx_wdata;
        end
    end

    // Transaction framing, shifting, sampling and buffer fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            granted   <= 1'b0;
            tx_sh     <= '0;
            rx_sh     <= '0;
            bit_cnt   <= '0;
            need_load <= 1'b0;
            cur_buf   <= 1'b0;
            tx_idx    <= '0;
            tx_amount <= '0;
            rx_amount <= '0;
            for (int i = 0; i < DEPTH; i++) rx_mem[i] <= '0;
        end else if (csn_fall) begin
            granted <= engine_owns;
            bit_cnt <= '0;
            rx_sh   <= '0;
            if (engine_owns) begin
                tx_amount <= '0;
                rx_amount <= '0;
            end
            if (!mode.cpha) begin
                tx_sh     <= pick_byte;
                cur_buf   <= pick_buf;
                tx_idx    <= pick_buf ? CNT_W'(1) : '0;
                need_load <= 1'b0;
            end else begin
                cur_buf   <= 1'b0;
                tx_idx    <= '0;
                need_load <= 1'b1;
            end
        end else if (csn_rise) begin
            granted <= 1'b0;
        end else if (!csn_s) begin
            if (shift_e) begin
                if (need_load) begin
                    tx_sh     <= pick_byte;
                    cur_buf   <= pick_buf;
                    need_load <= 1'b0;
                    if (pick_buf) tx_idx <= tx_idx + 1'b1;
                end else begin
                    tx_sh <= {tx_sh[6:0], 1'b0};
                end
            end
            if (sample_e) begin
                rx_sh   <= rx_next;
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == 3'd7) begin
                    need_load <= 1'b1;
                    if (granted && (rx_amount < rx_lim)) begin
                        rx_mem[rx_amount[AW-1:0]] <= rx_next;
                        rx_amount <= rx_amount + 1'b1;
                    end
                    if (cur_buf) tx_amount <= tx_amount + 1'b1;
                end
            end
        end
    end

    assign miso_bit      = tx_sh[7];
    assign start_grant   = csn_fall & engine_owns;
    assign end_pulse     = csn_rise & granted;
    assign host_rx_rdata = rx_mem[host_addr];
endmodule

// File: rtl/spis_target.sv
// Top of the SPI target: pin synchronisers, serial engine and ownership
// semaphore. MISO output enable follows the raw chip select pin so the
// line is released at once when the master deselects.
module spis_target
    import spis_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck,
    input  logic             csn_n,
    input  logic             mosi,
    output logic             miso_o,
    output logic             miso_oe,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic [7:0]       cfg_orc,
    input  logic [7:0]       cfg_def,
    input  logic             cfg_auto_acq,
    input  logic [CNT_W-1:0] tx_max,
    input  logic [CNT_W-1:0] rx_max,
    input  logic             task_acquire,
    input  logic             task_release,
    input  logic [1:0]       evt_clr,
    input  logic [1:0]       inten_set,
    input  logic [1:0]       inten_clr,
    input  logic [AW-1:0]    host_addr,
    input  logic             host_tx_we,
    input  logic [7:0]       host_tx_wdata,
    output logic [7:0]       host_rx_rdata,
    output logic             sem_host,
    output logic             evt_end,
    output logic             evt_acquired,
    output logic [1:0]       inten,
    output logic             irq,
    output logic [CNT_W-1:0] tx_amount,
    output logic [CNT_W-1:0] rx_amount
);
    logic [2:0]       pins_s;
    logic             engine_owns, granted, start_grant, end_pulse;
    logic [N_EVT-1:0] evt;
    spi_mode_t        mode;

    assign mode = '{cpol: cfg_cpol, cpha: cfg_cpha};

    spis_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck, csn_n, mosi}),
        .q     (pins_s)
    );

    spis_engine #(.DEPTH(DEPTH)) u_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode          (mode),
        .sck_s         (pins_s[2]),
        .csn_s         (pins_s[1]),
        .mosi_s        (pins_s[0]),
        .engine_owns   (engine_owns),
        .tx_max        (tx_max),
        .rx_max        (rx_max),
        .orc           (cfg_orc),
        .def           (cfg_def),
        .host_addr     (host_addr),
        .host_tx_we    (host_tx_we),
        .host_tx_wdata (host_tx_wdata),
        .host_rx_rdata (host_rx_rdata),
        .miso_bit      (miso_o),
        .granted       (granted),
        .start_grant   (start_grant),
        .end_pulse     (end_pulse),
        .tx_amount     (tx_amount),
        .rx_amount     (rx_amount)
    );

    spis_sema u_sema (
        .clk         (clk),
        .rst_n       (rst_n),
        .task_acq    (task_acquire),
        .task_rel    (task_release),
        .auto_acq    (cfg_auto_acq),
        .busy        (granted),
        .start_grant (start_grant),
        .end_pulse   (end_pulse),
        .evt_clr     (evt_clr),
        .inten_set   (inten_set),
        .inten_clr   (inten_clr),
        .sem_host    (sem_host),
        .engine_owns (engine_owns),
        .evt         (evt),
        .inten       (inten),
        .irq         (irq)
    );

    assign evt_end      = evt[EVT_END];
    assign evt_acquired = evt[EVT_ACQ];
    assign miso_oe      = ~csn_n;
endmodule

// File: rtl/spis_target_chk.sv
// Property checker for spis_target, attached by bind. Assumes the byte
// limits stay fixed while a granted transaction runs.
module spis_target_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             granted,
    input logic             start_grant,
    input logic             sem_host,
    input logic             evt_end,
    input logic             evt_acquired,
    input logic [CNT_W-1:0] tx_amount,
    input logic [CNT_W-1:0] rx_amount,
    input logic [CNT_W-1:0] tx_max,
    input logic [CNT_W-1:0] rx_max
);
    AST_SEM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        granted |-> !sem_host); // R8
    AST_ACQ_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_acquired) |-> sem_host); // R8
    AST_END_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_end) |-> $past(granted)); // R9
    AST_TX_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        granted |-> (tx_amount <= tx_max)); // R3
    AST_RX_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        granted |-> (rx_amount <= rx_max)); // R4
    AST_IDLE_AMT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!granted && !start_grant) |=> ($stable(rx_amount) && $stable(tx_amount))); // R6
endmodule

bind spis_target spis_target_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .granted      (granted),
    .start_grant  (start_grant),
    .sem_host     (sem_host),
    .evt_end      (evt_end),
    .evt_acquired (evt_acquired),
    .tx_amount    (tx_amount),
    .rx_amount    (rx_amount),
    .tx_max       (tx_max),
    .rx_max       (rx_max)
);

// File: tb/tb_spis_target.sv
// Bench for spis_target: a behavioural model of ownership, events and
// enables compared every clock, plus a master-side byte model per transfer.
module tb_spis_target;
    localparam int DEPTH = 8;
    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int HALF  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, csn_n = 1'b1, mosi = 1'b0;
    logic miso_o, miso_oe;
    logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_auto_acq = 1'b1;
    logic [7:0] cfg_orc = 8'h00, cfg_def = 8'h00;
    logic [CNT_W-1:0] tx_max = '0, rx_max = '0;
    logic task_acquire = 1'b0, task_release = 1'b0;
    logic [1:0] evt_clr = '0, inten_set = '0, inten_clr = '0;
    logic [AW-1:0] host_addr = '0;
    logic host_tx_we = 1'b0;
    logic [7:0] host_tx_wdata = '0, host_rx_rdata;
    logic sem_host, evt_end, evt_acquired, irq;
    logic [1:0] inten;
    logic [CNT_W-1:0] tx_amount, rx_amount;

    int n_chk = 0, n_fail = 0;
    bit track = 1'b0;
    bit m_host = 1'b1;
    bit [1:0] m_evt = '0, m_inten = '0;
    logic [7:0] mo [DEPTH];
    logic [7:0] got [DEPTH];

    always #2 clk = ~clk;

    spis_target #(.DEPTH(DEPTH)) dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the behavioural model.
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            chk(miso_oe == !csn_n, "R12 miso_oe", miso_oe, !csn_n);
            if (track) begin
                chk(sem_host == m_host, "R7 R8 sem_host", sem_host, m_host);
                chk({evt_acquired, evt_end} == m_evt, "R11 events", {evt_acquired, evt_end}, m_evt);
                chk(inten == m_inten, "R11 inten", inten, m_inten);
                chk(irq == |(m_evt & m_inten), "R11 irq", irq, |(m_evt & m_inten));
            end
        end
    end

    task automatic pulse_acq();
        @(negedge clk); task_acquire = 1'b1; m_host = 1'b1; m_evt[1] = 1'b1;
        @(negedge clk); task_acquire = 1'b0;
    endtask

    task automatic pulse_rel();
        @(negedge clk); task_release = 1'b1; m_host = 1'b0;
        @(negedge clk); task_release = 1'b0;
    endtask

    task automatic clr_evt(input logic [1:0] m);
        @(negedge clk); evt_clr = m; m_evt = m_evt & ~m;
        @(negedge clk); evt_clr = '0;
    endtask

    task automatic set_en(input logic [1:0] s, input logic [1:0] c);
        @(negedge clk); inten_set = s; inten_clr = c; m_inten = (m_inten | s) & ~c;
        @(negedge clk); inten_set = '0; inten_clr = '0;
    endtask

    task automatic wr_tx(input int a, input logic [7:0] d);
        @(negedge clk); host_addr = AW'(a); host_tx_wdata = d; host_tx_we = 1'b1;
        @(negedge clk); host_tx_we = 1'b0;
    endtask

    task automatic rd_rx(input int a, output logic [7:0] d);
        @(negedge clk); host_addr = AW'(a); #1; d = host_rx_rdata;
    endtask

    // Master side of one transfer of n bytes from mo[], captured into got[].
    task automatic spi_xfer(input bit pol, input bit pha, input int n, input bit mid_acq);
        track = 1'b0;
        @(negedge clk); cfg_cpol = pol; cfg_cpha = pha; sck = pol;
        repeat (HALF) @(negedge clk);
        csn_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b < n; b++) begin
            got[b] = '0;
            for (int i = 7; i >= 0; i--) begin
                if (!pha) begin
                    mosi = mo[b][i];
                    repeat (HALF) @(negedge clk);
                    got[b][i] = miso_o;
                    sck = ~pol;
                    repeat (HALF) @(negedge clk);
                    sck = pol;
                end else begin
                    sck = ~pol;
                    mosi = mo[b][i];
                    repeat (HALF) @(negedge clk);
                    got[b][i] = miso_o;
                    sck = pol;
                    repeat (HALF) @(negedge clk);
                end
            end
            if (mid_acq && b == 0) begin
                @(negedge clk); task_acquire = 1'b1;
                @(negedge clk); task_acquire = 1'b0;
                repeat (2) @(negedge clk);
                chk(sem_host == 1'b0, "R8 acquire deferred during transfer", sem_host, 0);
            end
        end
        repeat (HALF) @(negedge clk);
        csn_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        logic [7:0] rb;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk(sem_host == 1'b1, "R13 sem_host", sem_host, 1);
        chk({evt_acquired, evt_end} == 2'b00, "R13 events", {evt_acquired, evt_end}, 0);
        chk(inten == 2'b00 && irq == 1'b0, "R13 inten/irq", {inten, irq}, 0);
        chk(tx_amount == 0 && rx_amount == 0, "R13 amounts", {tx_amount, rx_amount}, 0);
        chk(miso_oe == 1'b0, "R12 miso_oe reset", miso_oe, 0);
        rd_rx(0, rb);
        chk(rb == 8'h00, "R13 rx buffer", rb, 0);
        track = 1'b1;

        wr_tx(0, 8'h3C); wr_tx(1, 8'h81); wr_tx(2, 8'h7E); wr_tx(3, 8'h12);
        cfg_def = 8'h5A; cfg_orc = 8'hE7; tx_max = 4; rx_max = 4;

        // R6: host owns, transfer sends default char only
        mo[0] = 8'hC3; mo[1] = 8'h99;
        spi_xfer(0, 0, 2, 0);
        chk(got[0] == 8'h5A && got[1] == 8'h5A, "R6 default char", {got[0], got[1]}, 16'h5A5A);
        chk(tx_amount == 0 && rx_amount == 0, "R6 amounts unchanged", {tx_amount, rx_amount}, 0);
        chk(evt_end == 1'b0, "R6 no end event", evt_end, 0);
        rd_rx(0, rb);
        chk(rb == 8'h00, "R6 rx buffer untouched", rb, 0);
        track = 1'b1;

        // R7 release, then mode 0 full transfer: R1 R2 R3 R4 R9 R10
        pulse_rel();
        @(negedge clk);
        chk(sem_host == 1'b0, "R7 sem_host after release", sem_host, 0);
        mo[0] = 8'h11; mo[1] = 8'h22; mo[2] = 8'h84; mo[3] = 8'hF0;
        spi_xfer(0, 0, 4, 0);
        chk(got[0] == 8'h3C && got[1] == 8'h81 && got[2] == 8'h7E && got[3] == 8'h12,
            "R1 R2 R3 mode0 miso", {got[0], got[1], got[2], got[3]}, 32'h3C817E12);
        chk(tx_amount == 4 && rx_amount == 4, "R3 R4 amounts mode0", {tx_amount, rx_amount}, 8'h44);
        for (int k = 0; k < 4; k++) begin
            rd_rx(k, rb);
            chk(rb == mo[k], "R4 rx store mode0", rb, mo[k]);
        end
        chk(evt_end == 1'b1, "R9 end event", evt_end, 1);
        chk(sem_host == 1'b1 && evt_acquired == 1'b1, "R10 auto acquire", {sem_host, evt_acquired}, 3);
        m_evt = 2'b11; m_host = 1'b1; track = 1'b1;
        clr_evt(2'b11);

        // Mode 1 with limits: R5 over-read, R4 drop beyond rx_max
        pulse_rel();
        tx_max = 2; rx_max = 1;
        mo[0] = 8'hA0; mo[1] = 8'h0B; mo[2] = 8'h55; mo[3] = 8'h66;
        spi_xfer(0, 1, 4, 0);
        chk(got[0] == 8'h3C && got[1] == 8'h81, "R1 R3 mode1 buffer bytes", {got[0], got[1]}, 16'h3C81);
        chk(got[2] == 8'hE7 && got[3] == 8'hE7, "R5 over-read char", {got[2], got[3]}, 16'hE7E7);
        chk(tx_amount == 2 && rx_amount == 1, "R3 R4 amounts mode1", {tx_amount, rx_amount}, 8'h21);
        rd_rx(0, rb); chk(rb == 8'hA0, "R4 rx first byte", rb, 8'hA0);
        rd_rx(1, rb); chk(rb == 8'h22, "R4 rx beyond limit dropped", rb, 8'h22);
        m_evt = 2'b11; m_host = 1'b1; track = 1'b1;
        clr_evt(2'b11);

        // Mode 2, no auto acquire: R10 off, then R8 acquire task
        cfg_auto_acq = 1'b0;
        tx_max = 3; rx_max = 8;
        pulse_rel();
        mo[0] = 8'h01; mo[1] = 8'h80; mo[2] = 8'h7F;
        spi_xfer(1, 0, 3, 0);
        chk(got[0] == 8'h3C && got[1] == 8'h81 && got[2] == 8'h7E, "R1 mode2 miso",
            {got[0], got[1], got[2]}, 24'h3C817E);
        chk(evt_end == 1'b1 && sem_host == 1'b0, "R10 no auto acquire", {evt_end, sem_host}, 2);
        m_evt = 2'b01; m_host = 1'b0; track = 1'b1;
        pulse_acq();
        chk(sem_host == 1'b1 && evt_acquired == 1'b1, "R8 acquire task", {sem_host, evt_acquired}, 3);
        clr_evt(2'b11);

        // Mode 3, tx_max 0, acquire mid-transfer deferred to end: R8 R5
        tx_max = 0;
        pulse_rel();
        mo[0] = 8'h5C; mo[1] = 8'hC5;
        spi_xfer(1, 1, 2, 1);
        chk(got[0] == 8'hE7 && got[1] == 8'hE7, "R1 R5 mode3 over-read", {got[0], got[1]}, 16'hE7E7);
        chk(tx_amount == 0 && rx_amount == 2, "R3 R4 amounts mode3", {tx_amount, rx_amount}, 2);
        chk(sem_host == 1'b1 && evt_acquired == 1'b1, "R8 deferred grant at end", {sem_host, evt_acquired}, 3);
        rd_rx(1, rb); chk(rb == 8'hC5, "R2 R4 rx mode3", rb, 8'hC5);
        m_evt = 2'b11; m_host = 1'b1; track = 1'b1;
        clr_evt(2'b11);

        // R11 interrupt enables and events
        set_en(2'b01, 2'b00);
        pulse_acq();
        chk(irq == 1'b0, "R11 disabled event no irq", irq, 0);
        set_en(2'b10, 2'b00);
        chk(irq == 1'b1, "R11 enabled event irq", irq, 1);
        set_en(2'b00, 2'b11);
        chk(inten == 2'b00 && irq == 1'b0, "R11 clear all enables", {inten, irq}, 0);
        chk(evt_acquired == 1'b1, "R11 event sticky", evt_acquired, 1);
        clr_evt(2'b10);
        chk(evt_acquired == 1'b0, "R11 event clear", evt_acquired, 0);

        repeat (4) @(negedge clk);
        summary();
    end
endmodule